// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Zero-Turnaround Writes

This block is a small synchronous static memory with a flow-through read path. One command is taken on each enabled rising clock edge: a new read, a new write, a continuation of the current burst, or a deselect. Reads and writes may follow each other in any order on consecutive edges. No idle cycle is needed when the bus turns from writing to reading or back.

A read presents its data during the cycle that follows the edge that took its address. No output register sits in that path. A write takes its address on one edge and its data and byte selects on the next edge, and the memory is updated on that second edge. A read of the same word issued on that second edge therefore returns the newly merged bytes. A clock enable freezes every register. Three chip enables, all active high, qualify each new command. A two-bit burst counter steps through four words in linear or interleaved order.

The data output is paired with a drive-enable signal that acts in place of a tri-state control. The drive enable is high only while read data is being presented and the asynchronous output enable is high. It is therefore low during the data cycle of a write, so an external bus cannot see contention.

Top module: `ft_sram`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it is released before any read, `drive_en` is 0 and `rdata` is all zeros.
- R2: A read taken at an enabled edge (`adv`=0, all three chip enables high, `wr`=0) sets `drive_en` to 1 and presents the addressed word on `rdata` during the cycle that follows that edge.
- R3: A write taken at an enabled edge (`adv`=0, all chip enables high, `wr`=1) samples `wdata` and `wbe` on the next enabled edge. Only byte lanes `b` with `wbe[b]`=1 (bits `8b+7:8b`) change.
- R4: A write followed on the very next edge by a read of the same word returns the merged new bytes. A read followed by a write needs no idle cycle.
- R5: If any chip enable is low at a load edge (`adv`=0), the cycle is a deselect: `drive_en` stays 0 and no word is written.
- R6: With `cke` low, no input is sampled and all state and outputs hold. A write whose data edge falls in a stall takes its data at the next edge with `cke` high.
- R7: With `oe` low, `drive_en` is 0 and `rdata` is zero at once, without waiting for a clock edge.
- R8: During the data cycle of a write, `drive_en` is 0 even with `oe` high.
- R9: With `ilv`=0 at the load edge, each following edge with `adv`=1 adds 1 modulo 4 to address bits [1:0] and keeps the upper bits. The fourth advance returns to the load address.
- R10: With `ilv`=1 at the load edge, the k-th access of the burst uses address bits [1:0] equal to the load value XOR k.
- R11: An advance (`adv`=1) continues the kind of operation that is in progress, either read or write. An advance after a deselect is itself a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe` are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes all state |
| cs_a | input | 1 | Chip enable A, active high |
| cs_b | input | 1 | Chip enable B, active high |
| cs_c | input | 1 | Chip enable C, active high |
| wr | input | 1 | 1 = write command, 0 = read command (load edges only) |
| adv | input | 1 | 1 = advance the burst, 0 = load a new address |
| ilv | input | 1 | Burst order taken at load: 1 = interleaved, 0 = linear |
| addr | input | AW | Word address taken at load |
| wdata | input | NB*BW | Write data, sampled one enabled edge after the write's address |
| wbe | input | NB | Byte write selects, sampled together with `wdata` |
| oe | input | 1 | Asynchronous output enable, active high |
| rdata | output | NB*BW | Read data; zero whenever `drive_en` is 0 |
| drive_en | output | 1 | High while `rdata` should be driven onto the bus |

## Verification
Read data is due in the same cycle that follows the address edge. The bench drives each command at a falling edge and compares `rdata` and `drive_en` at the next falling edge, half a period after the capturing rising edge. Write data is driven at the falling edge that follows the write command, so it is taken one rising edge after the address. The write-to-read case issues the read in that same cycle and expects the merged word at the falling edge after. Output-enable gating is combinational, so it is checked 1 time unit after `oe` changes, inside the same cycle. Stall cases count the frozen edges and expect the pending read data or write data to wait for the first edge with `cke` high.

// File: rtl/ft_sram_pkg.sv
package ft_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    localparam int STEP_W = 2;

    // Low address bits of the k-th access of a burst
    function automatic logic [STEP_W-1:0] burst_lsb(
        input logic [STEP_W-1:0] base,
        input logic [STEP_W-1:0] step,
        input logic              interleave
    );
        logic [STEP_W-1:0] res;
        if (interleave) begin
            res = base ^ step;
        end else begin
            res = base + step;
        end
        return res;
    endfunction

endpackage

// File: rtl/ft_sram_ctrl.sv
module ft_sram_ctrl
    import ft_sram_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NCS = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cke,
    input  logic           adv,
    input  logic           wr,
    input  logic           ilv,
    input  logic [NCS-1:0] cs,
    input  logic [AW-1:0]  addr,
    output op_e            op,
    output logic [AW-1:0]  acc_addr,
    output logic           ilv_act
);

    typedef struct packed {
        op_e               op;
        logic [AW-1:0]     base;
        logic [STEP_W-1:0] cnt;
        logic              ilv;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cke) begin
            if (!adv) begin
                if (&cs) begin
                    st_d.op   = wr ? OP_WR : OP_RD;
                    st_d.base = addr;
                    st_d.cnt  = '0;
                    st_d.ilv  = ilv;
                end else begin
                    st_d.op = OP_IDLE;
                end
            end else if (st_q.op != OP_IDLE) begin
                st_d.cnt = st_q.cnt + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op       = st_q.op;
    assign ilv_act  = st_q.ilv;
    assign acc_addr = {st_q.base[AW-1:STEP_W],
                       burst_lsb(st_q.base[STEP_W-1:0], st_q.cnt, st_q.ilv)};

endmodule

// File: rtl/ft_sram_array.sv
module ft_sram_array #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    acc_addr,
    input  logic [NB*BW-1:0] wdata,
    input  logic [NB-1:0]    wbe,
    output logic [NB*BW-1:0] rdata_raw
);

    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wbe[b]) begin
                lane_q[acc_addr] <= wdata[b*BW +: BW];
            end
        end

        assign rdata_raw[b*BW +: BW] = lane_q[acc_addr];
    end

endmodule

// File: rtl/ft_sram_outmux.sv
module ft_sram_outmux
    import ft_sram_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          oe,
    input  op_e           op,
    input  logic [DW-1:0] rdata_raw,
    output logic [DW-1:0] rdata,
    output logic          drive_en
);

    always_comb begin
        drive_en = oe && (op == OP_RD);
        rdata    = drive_en ? rdata_raw : '0;
    end

endmodule

// File: rtl/ft_sram.sv
module ft_sram
    import ft_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cs_a,
    input  logic             cs_b,
    input  logic             cs_c,
    input  logic             wr,
    input  logic             adv,
    input  logic             ilv,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] wdata,
    input  logic [NB-1:0]    wbe,
    input  logic             oe,
    output logic [NB*BW-1:0] rdata,
    output logic             drive_en
);

    localparam int DW  = NB * BW;
    localparam int NCS = 3;

    op_e           op_w;
    logic [AW-1:0] acc_addr_w;
    logic          ilv_w;
    logic [DW-1:0] raw_w;
    logic          wr_en_w;

    ft_sram_ctrl #(.AW(AW), .NCS(NCS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .adv      (adv),
        .wr       (wr),
        .ilv      (ilv),
        .cs       ({cs_c, cs_b, cs_a}),
        .addr     (addr),
        .op       (op_w),
        .acc_addr (acc_addr_w),
        .ilv_act  (ilv_w)
    );

    // The data edge of a write commits directly into the array
    assign wr_en_w = cke && (op_w == OP_WR);

    ft_sram_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
        .clk       (clk),
        .wr_en     (wr_en_w),
        .acc_addr  (acc_addr_w),
        .wdata     (wdata),
        .wbe       (wbe),
        .rdata_raw (raw_w)
    );

    ft_sram_outmux #(.DW(DW)) u_outmux (
        .oe        (oe),
        .op        (op_w),
        .rdata_raw (raw_w),
        .rdata     (rdata),
        .drive_en  (drive_en)
    );

endmodule

// File: rtl/ft_sram_chk.sv
module ft_sram_chk
    import ft_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke,
    input logic          adv,
    input logic          cs_a,
    input logic          cs_b,
    input logic          cs_c,
    input logic          oe,
    input logic          drive_en,
    input op_e           cur_op,
    input logic [AW-1:0] cur_addr,
    input logic          cur_ilv
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_op == OP_IDLE) && !drive_en);

    p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !adv && !(cs_a && cs_b && cs_c)) |=> (cur_op == OP_IDLE));

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(cur_op) && $stable(cur_addr));

    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !drive_en);

    p_no_drive_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == OP_WR) |-> !drive_en);

    p_linear_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && adv && (cur_op != OP_IDLE) && !cur_ilv)
        |=> cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1));

    p_adv_keep_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && adv) |=> $stable(cur_op));

endmodule

bind ft_sram ft_sram_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .adv      (adv),
    .cs_a     (cs_a),
    .cs_b     (cs_b),
    .cs_c     (cs_c),
    .oe       (oe),
    .drive_en (drive_en),
    .cur_op   (op_w),
    .cur_addr (acc_addr_w),
    .cur_ilv  (ilv_w)
);

// File: tb/ft_sram_bench.sv
module ft_sram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int BW = 8;
    localparam int DW = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n, cke, cs_a, cs_b, cs_c, wr, adv, ilv, oe;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [NB-1:0] wbe;
    logic [DW-1:0] rdata;
    logic          drive_en;

    logic [DW-1:0] model [1 << AW];
    int n_vec = 0;
    int n_bad = 0;

    ft_sram #(.AW(AW), .NB(NB), .BW(BW)) u_ft_sram (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c),
        .wr(wr), .adv(adv), .ilv(ilv), .addr(addr), .wdata(wdata), .wbe(wbe),
        .oe(oe), .rdata(rdata), .drive_en(drive_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [NB-1:0] be);
        logic [DW-1:0] r = old;
        for (int b = 0; b < NB; b++) if (be[b]) r[b*BW +: BW] = nw[b*BW +: BW];
        return r;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_cmd();
        cs_a = 1'b0; cs_b = 1'b0; cs_c = 1'b0; adv = 1'b0; wr = 1'b0;
    endtask

    task automatic set_cmd(input logic a_adv, input logic a_wr, input logic [AW-1:0] a_addr);
        cs_a = 1'b1; cs_b = 1'b1; cs_c = 1'b1; adv = a_adv; wr = a_wr; addr = a_addr;
    endtask

    task automatic wr_single(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] be);
        set_cmd(1'b0, 1'b1, a);
        tick();
        wdata = d; wbe = be;
        idle_cmd();
        tick();
        model[a] = merge(model[a], d, be);
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input string req);
        set_cmd(1'b0, 1'b0, a);
        tick();
        check(req, {31'd0, drive_en}, 32'd1);
        check(req, rdata, model[a]);
        idle_cmd();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cke = 1'b1; oe = 1'b1; ilv = 1'b0; addr = '0;
        wdata = '0; wbe = '0; idle_cmd();
        repeat (3) tick();
        check("R1 drive_en in reset", {31'd0, drive_en}, 32'd0);
        check("R1 rdata in reset", rdata, '0);
        rst_n = 1'b1;
        tick();
        check("R1 drive_en after reset", {31'd0, drive_en}, 32'd0);
        check("R1 rdata after reset", rdata, '0);
    endtask

    task automatic t_basic();
        wr_single(6'd5, 32'h0102_0304, 4'b1111);
        rd_check(6'd5, "R2 flow-through read");
        wr_single(6'd5, 32'hAABB_CCDD, 4'b0101);
        set_cmd(1'b0, 1'b0, 6'd5);
        tick();
        check("R3 byte-masked write", rdata, 32'h01BB_03DD);
        idle_cmd();
    endtask

    task automatic t_b2b();
        wr_single(6'd9, 32'hA5A5_A5A5, 4'b1111);
        set_cmd(1'b0, 1'b1, 6'd9);
        tick();
        wdata = 32'h1234_5678; wbe = 4'b0011;
        set_cmd(1'b0, 1'b0, 6'd9);
        tick();
        check("R4 write-then-read merged", rdata, 32'hA5A5_5678);
        model[9] = 32'hA5A5_5678;
        set_cmd(1'b0, 1'b1, 6'd10);
        tick();
        check("R8 drive_en in write data cycle", {31'd0, drive_en}, 32'd0);
        wdata = 32'hCAFE_F00D; wbe = 4'b1111;
        set_cmd(1'b0, 1'b0, 6'd10);
        tick();
        model[10] = 32'hCAFE_F00D;
        check("R4 read-write-read no gap", rdata, 32'hCAFE_F00D);
        idle_cmd();
    endtask

    task automatic t_desel();
        for (int k = 0; k < 3; k++) begin
            set_cmd(1'b0, 1'b0, 6'd5);
            if (k == 0) cs_a = 1'b0;
            if (k == 1) cs_b = 1'b0;
            if (k == 2) cs_c = 1'b0;
            tick();
            check("R5 deselect no drive", {31'd0, drive_en}, 32'd0);
            check("R5 deselect rdata", rdata, '0);
        end
        set_cmd(1'b0, 1'b1, 6'd5);
        cs_b = 1'b0;
        tick();
        wdata = 32'hDEAD_BEEF; wbe = 4'b1111;
        idle_cmd();
        tick();
        rd_check(6'd5, "R5 deselected write ignored");
    endtask

    task automatic t_cke();
        set_cmd(1'b0, 1'b0, 6'd5);
        tick();
        check("R6 read before stall", rdata, model[5]);
        cke = 1'b0;
        set_cmd(1'b0, 1'b0, 6'd9);
        tick();
        tick();
        check("R6 drive held in stall", {31'd0, drive_en}, 32'd1);
        check("R6 rdata held in stall", rdata, model[5]);
        cke = 1'b1;
        tick();
        check("R6 command after stall", rdata, model[9]);
        wr_single(6'd12, 32'h1111_1111, 4'b1111);
        set_cmd(1'b0, 1'b1, 6'd12);
        tick();
        cke = 1'b0;
        wdata = 32'hBAD0_BAD0; wbe = 4'b1111;
        idle_cmd();
        tick();
        tick();
        cke = 1'b1;
        wdata = 32'h600D_CAFE;
        tick();
        model[12] = 32'h600D_CAFE;
        rd_check(6'd12, "R6 deferred write data");
    endtask

    task automatic t_oe();
        set_cmd(1'b0, 1'b0, 6'd5);
        tick();
        oe = 1'b0;
        #1;
        check("R7 oe low drive_en", {31'd0, drive_en}, 32'd0);
        check("R7 oe low rdata", rdata, '0);
        oe = 1'b1;
        #1;
        check("R7 oe high again", rdata, model[5]);
        idle_cmd();
    endtask

    task automatic t_linear();
        logic [AW-1:0] seq [5] = '{6'd18, 6'd19, 6'd16, 6'd17, 6'd18};
        for (int i = 0; i < 4; i++) wr_single(6'(16 + i), 32'hB000_0000 + 32'(i * 17 + 3), 4'b1111);
        ilv = 1'b0;
        set_cmd(1'b0, 1'b0, 6'd18);
        tick();
        check("R9 linear load", rdata, model[seq[0]]);
        set_cmd(1'b1, 1'b0, 6'd0);
        for (int i = 1; i < 5; i++) begin
            tick();
            check("R9 linear step", rdata, model[seq[i]]);
        end
        idle_cmd();
    endtask

    task automatic t_ilv();
        logic [AW-1:0] seq [4] = '{6'd17, 6'd16, 6'd19, 6'd18};
        ilv = 1'b1;
        set_cmd(1'b0, 1'b0, 6'd17);
        tick();
        ilv = 1'b0;
        check("R10 interleaved load", rdata, model[seq[0]]);
        set_cmd(1'b1, 1'b0, 6'd0);
        for (int i = 1; i < 4; i++) begin
            tick();
            check("R10 interleaved step", rdata, model[seq[i]]);
        end
        idle_cmd();
    endtask

    task automatic t_wburst();
        set_cmd(1'b0, 1'b1, 6'd20);
        tick();
        wdata = 32'h2020_2020; wbe = 4'b1111;
        set_cmd(1'b1, 1'b0, 6'd0);
        tick();
        check("R11 write burst keeps drive off", {31'd0, drive_en}, 32'd0);
        wdata = 32'h2121_2121;
        idle_cmd();
        tick();
        model[20] = 32'h2020_2020;
        model[21] = 32'h2121_2121;
        rd_check(6'd20, "R11 write burst word 0");
        rd_check(6'd21, "R11 write burst word 1");
        tick();
        set_cmd(1'b1, 1'b0, 6'd0);
        tick();
        check("R11 advance after deselect", {31'd0, drive_en}, 32'd0);
        idle_cmd();
        tick();
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        t_reset();
        for (int i = 0; i < (1 << AW); i++) wr_single(6'(i), '0, 4'b1111);
        t_basic();
        t_b2b();
        t_desel();
        t_cke();
        t_oe();
        t_linear();
        t_ilv();
        t_wburst();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule